// File: doc/BRIEF.md
# Floppy Drive Line Sequencer

This block drives the addressing lines and the latch strobe of a floppy drive: three phase/address lines, one head-select line and one strobe line. A command names a 4-bit drive register code and a kind. An action command addresses a drive register and pulses the strobe, so that the drive latches a command such as a step, a seek direction, a motor change, an eject or a recording-mode change. A sense command addresses a status line of the drive and samples the drive's single sense input.

Every access starts by parking the three address lines at the neutral code 3. The head-select line is changed only while the lines are parked, and only after that is the target address driven. Each phase lasts a whole number of microseconds, derived from a clock-rate parameter. The sense input is synchronised through two flip-flops. The drive pulls the sense line low to report a true condition, so the sampled level is inverted into the status bit. While a sequence runs the block reports busy, and it discards any command that arrives, flagging the loss.

Top module: `drv_line_seq`

## Requirements
- R1: After reset, addr_o is 3, sel_o is 0, and strb_o, busy_o, sense_o, sense_vld_o and cmd_drop_o are all 0.
- R2: A command is accepted on a clock edge where cmd_valid_i is 1 and busy_o is 0. From that edge addr_o is 3 for two cycles. During the first of these cycles sel_o keeps its previous value, and during the second it takes bit 3 of cmd_code_i.
- R3: In the third cycle after acceptance, addr_o takes bits 2:0 of the code and holds them until the next accepted command. sel_o stays at code bit 3 over the same span. Every code from 0 to 15 is handled alike. Examples of action codes: 0 seek outward, 4 seek inward, 1 step, 2 motor on, 6 motor off, 3 index, 7 eject, 9 MFM mode, 13 GCR mode.
- R4: For an action (cmd_act_i=1), strb_o rises after the target address has been held for SETUP_US*CLK_MHZ cycles. It stays high for STRB_US*CLK_MHZ cycles. busy_o then stays 1 for HOLD_US*CLK_MHZ more cycles before it falls.
- R5: For a sense (cmd_act_i=0), once the target address has been held for SETUP_US*CLK_MHZ cycles, sense_o takes the inverse of the synchronised sense_i. In that same cycle sense_vld_o pulses for one cycle and busy_o falls. strb_o stays 0 throughout.
- R6: busy_o is 1 from the acceptance edge until the sequence ends. A command presented while busy_o is 1 is ignored: one cycle later cmd_drop_o is 1 for one cycle, and the lines, the timing and sense_o proceed as if the command had not been presented.
- R7: sense_o keeps its value until the next sense command completes. Action commands leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, CLK_MHZ MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_act_i | input | 1 | 1 = action with strobe, 0 = sense |
| cmd_code_i | input | 4 | Drive register code; bit 3 selects head line |
| sense_i | input | 1 | Asynchronous drive sense line, low = true |
| addr_o | output | 3 | Drive address lines |
| sel_o | output | 1 | Head-select line |
| strb_o | output | 1 | Latch strobe |
| busy_o | output | 1 | Sequence in progress |
| sense_o | output | 1 | Last sensed condition, inverted from the line |
| sense_vld_o | output | 1 | One-cycle pulse when sense_o is updated |
| cmd_drop_o | output | 1 | One-cycle pulse for a command ignored while busy |

## Verification
Two events can fall in the same cycle: the final cycle of a sequence (the end of the hold time, or the sense sample) and the arrival of a new request. The bench provokes this by raising cmd_valid_i in the last cycle in which busy_o is still 1. It then checks that the request is dropped, that no new park phase starts, that the address lines stay at the finished target, and that a sense result is still delivered. A drop in the middle of a sequence is judged the same way, against the cycle-by-cycle line pattern that the bench computes for the undisturbed command.

// File: rtl/drv_line_pkg.sv
package drv_line_pkg;
  localparam logic [2:0] ADDR_PARK = 3'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PARK, ST_SEL, ST_SETUP, ST_STRB, ST_HOLD
  } seq_st_e;

  // action codes
  localparam logic [3:0] ACT_STEP      = 4'd1;
  localparam logic [3:0] ACT_EJECT     = 4'd7;
  localparam logic [3:0] ACT_MOTOR_ON  = 4'd2;
  localparam logic [3:0] ACT_MOTOR_OFF = 4'd6;
  localparam logic [3:0] ACT_DIR_OUT   = 4'd0;
  localparam logic [3:0] ACT_DIR_IN    = 4'd4;
  localparam logic [3:0] ACT_INDEX     = 4'd3;
  localparam logic [3:0] ACT_MODE_GCR  = 4'd13;
  localparam logic [3:0] ACT_MODE_MFM  = 4'd9;

  // sense codes
  localparam logic [3:0] SNS_TRK0      = 4'd10;
  localparam logic [3:0] SNS_MEDIA_IN  = 4'd8;
  localparam logic [3:0] SNS_WPROT     = 4'd9;
  localparam logic [3:0] SNS_SEEK_DONE = 4'd14;
  localparam logic [3:0] SNS_PRESENT   = 4'd7;
  localparam logic [3:0] SNS_TACH      = 4'd11;
endpackage

// File: rtl/drv_sync2.sv
module drv_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/drv_phase_cnt.sv
module drv_phase_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/drv_line_seq.sv
module drv_line_seq
  import drv_line_pkg::*;
#(
  parameter int CLK_MHZ  = 50,
  parameter int SETUP_US = 1,
  parameter int STRB_US  = 2,
  parameter int HOLD_US  = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic       cmd_act_i,
  input  logic [3:0] cmd_code_i,
  input  logic       sense_i,
  output logic [2:0] addr_o,
  output logic       sel_o,
  output logic       strb_o,
  output logic       busy_o,
  output logic       sense_o,
  output logic       sense_vld_o,
  output logic       cmd_drop_o
);
  localparam int SETUP_CYC = CLK_MHZ * SETUP_US;
  localparam int STRB_CYC  = CLK_MHZ * STRB_US;
  localparam int HOLD_CYC  = CLK_MHZ * HOLD_US;
  localparam int MAX_CYC   = (SETUP_CYC > STRB_CYC)
                             ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                             : ((STRB_CYC > HOLD_CYC) ? STRB_CYC : HOLD_CYC);
  localparam int CNT_W     = $clog2(MAX_CYC) + 1;

  seq_st_e     st_q;
  logic [2:0]  addr_q;
  logic        sel_q, strb_q, busy_q, sense_q, vld_q, drop_q;
  logic [3:0]  code_q;
  logic        act_q;
  logic        sns_s;
  logic        cnt_zero, cnt_ld;
  logic [CNT_W-1:0] cnt_val;

  drv_sync2 u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sense_i),
    .q_o    (sns_s)
  );

  // phase length reload
  always_comb begin
    cnt_ld  = 1'b0;
    cnt_val = '0;
    unique case (st_q)
      ST_SEL: begin
        cnt_ld  = 1'b1;
        cnt_val = CNT_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (cnt_zero && act_q) begin
        cnt_ld  = 1'b1;
        cnt_val = CNT_W'(STRB_CYC - 1);
      end
      ST_STRB: if (cnt_zero) begin
        cnt_ld  = 1'b1;
        cnt_val = CNT_W'(HOLD_CYC - 1);
      end
      default: ;
    endcase
  end

  drv_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_ld),
    .val_i  (cnt_val),
    .zero_o (cnt_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= ADDR_PARK;
      sel_q   <= 1'b0;
      strb_q  <= 1'b0;
      busy_q  <= 1'b0;
      sense_q <= 1'b0;
      vld_q   <= 1'b0;
      drop_q  <= 1'b0;
      code_q  <= '0;
      act_q   <= 1'b0;
    end else begin
      vld_q  <= 1'b0;
      drop_q <= cmd_valid_i && busy_q;
      unique case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          st_q   <= ST_PARK;
          addr_q <= ADDR_PARK;
          busy_q <= 1'b1;
          code_q <= cmd_code_i;
          act_q  <= cmd_act_i;
        end
        ST_PARK: begin
          sel_q <= code_q[3];   // head line moves only while parked
          st_q  <= ST_SEL;
        end
        ST_SEL: begin
          addr_q <= code_q[2:0];
          st_q   <= ST_SETUP;
        end
        ST_SETUP: if (cnt_zero) begin
          if (act_q) begin
            strb_q <= 1'b1;
            st_q   <= ST_STRB;
          end else begin
            sense_q <= ~sns_s;  // line low = condition true
            vld_q   <= 1'b1;
            busy_q  <= 1'b0;
            st_q    <= ST_IDLE;
          end
        end
        ST_STRB: if (cnt_zero) begin
          strb_q <= 1'b0;
          st_q   <= ST_HOLD;
        end
        ST_HOLD: if (cnt_zero) begin
          busy_q <= 1'b0;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_o      = addr_q;
  assign sel_o       = sel_q;
  assign strb_o      = strb_q;
  assign busy_o      = busy_q;
  assign sense_o     = sense_q;
  assign sense_vld_o = vld_q;
  assign cmd_drop_o  = drop_q;
endmodule

// File: rtl/drv_line_seq_chk.sv
module drv_line_seq_chk #(
  parameter int CLK_MHZ = 50,
  parameter int STRB_US = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [2:0] addr_o,
  input logic       sel_o,
  input logic       strb_o,
  input logic       busy_o,
  input logic       sense_vld_o,
  input logic       cmd_drop_o
);
  localparam int STRB_CYC = CLK_MHZ * STRB_US;

  logic [15:0] strb_w;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     strb_w <= '0;
    else if (strb_o) strb_w <= strb_w + 16'd1;
    else             strb_w <= '0;
  end

  assert_sel_parked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_o) |-> (addr_o == 3'd3 && $past(addr_o) == 3'd3));

  assert_addr_moves_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_o) |-> busy_o);

  assert_strb_addr_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_o |-> ($stable(addr_o) && $stable(sel_o) && busy_o));

  assert_strb_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_o) |-> (strb_w == 16'(STRB_CYC) && busy_o));

  assert_sense_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_vld_o |-> (!busy_o && $past(busy_o) && !strb_o));

  assert_drop_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_o) |=> cmd_drop_o);

  assert_no_false_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !cmd_drop_o);
endmodule

bind drv_line_seq drv_line_seq_chk #(.CLK_MHZ(CLK_MHZ), .STRB_US(STRB_US)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .addr_o      (addr_o),
  .sel_o       (sel_o),
  .strb_o      (strb_o),
  .busy_o      (busy_o),
  .sense_vld_o (sense_vld_o),
  .cmd_drop_o  (cmd_drop_o)
);

// File: tb/sim_drv_line_seq.sv
module sim_drv_line_seq;
  localparam int MHZ = 4;
  localparam int NS  = MHZ * 1;
  localparam int NB  = MHZ * 2;
  localparam int NH  = MHZ * 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, act = 1'b0;
  logic [3:0] code = '0;
  logic [15:0] pat = 16'hB38D;
  logic [2:0] addr;
  logic       sel, strb, busy, sns, vld, drop;
  logic       sense_line;

  int n_run = 0, n_fail = 0;
  bit fin = 0;
  bit m_sel = 0, m_sns = 0;

  always #10 clk = ~clk;

  assign sense_line = pat[{sel, addr}];

  drv_line_seq #(.CLK_MHZ(MHZ)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_act_i(act),
    .cmd_code_i(code), .sense_i(sense_line), .addr_o(addr), .sel_o(sel),
    .strb_o(strb), .busy_o(busy), .sense_o(sns), .sense_vld_o(vld),
    .cmd_drop_o(drop)
  );

  task automatic chk(input bit ok, input string req, input int a, input int e);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  // issue one command; inj >= 0 presents a competing request at cycle inj
  task automatic run_cmd(input bit k_act, input logic [3:0] k_code, input int inj);
    int t = k_act ? 2 + NS + NB + NH : 2 + NS;
    int e_park = 0, e_tgt = 0, e_tim = 0, e_drop = 0;
    bit exp_sns = k_act ? m_sns : ~pat[k_code];
    @(negedge clk);
    valid = 1'b1; act = k_act; code = k_code;
    @(negedge clk);
    valid = 1'b0;
    for (int k = 0; k <= t + 1; k++) begin
      bit e_busy = (k < t);
      bit e_strb = k_act && (k >= 2 + NS) && (k < 2 + NS + NB);
      bit e_vld  = !k_act && (k == t);
      bit e_drp  = (inj >= 0) && (k == inj + 1);
      if (k < 2) begin
        if (addr !== 3'd3) e_park++;
        if (sel !== ((k == 0) ? m_sel : k_code[3])) e_park++;
      end else begin
        if (addr !== k_code[2:0] || sel !== k_code[3]) e_tgt++;
      end
      if (busy !== e_busy || strb !== e_strb || vld !== e_vld) e_tim++;
      if (k >= t && sns !== exp_sns) e_tim++;
      if (k < t && sns !== m_sns) e_tim++;
      if (drop !== e_drp) e_drop++;
      if (k == inj) begin
        valid = 1'b1; act = ~k_act; code = ~k_code;
      end else begin
        valid = 1'b0;
      end
      @(negedge clk);
    end
    valid = 1'b0;
    chk(e_park == 0, $sformatf("R2 park code=%0d act=%0b", k_code, k_act), e_park, 0);
    chk(e_tgt == 0, $sformatf("R3 target code=%0d act=%0b", k_code, k_act), e_tgt, 0);
    if (k_act) chk(e_tim == 0, $sformatf("R4 timing code=%0d", k_code), e_tim, 0);
    else       chk(e_tim == 0, $sformatf("R5 sense code=%0d", k_code), e_tim, 0);
    if (k_act) chk(sns === m_sns, "R7 sense kept over action", sns, m_sns);
    chk(e_drop == 0, $sformatf("R6 drop flag code=%0d inj=%0d", k_code, inj), e_drop, 0);
    m_sel = k_code[3];
    m_sns = exp_sns;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(addr === 3'd3 && sel === 1'b0 && strb === 1'b0 && busy === 1'b0 &&
        sns === 1'b0 && vld === 1'b0 && drop === 1'b0, "R1 reset state",
        {addr, sel, strb, busy, sns, vld, drop}, 9'b011000000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // full sweep of both kinds over all codes
    for (int kd = 0; kd < 2; kd++) begin
      for (int c = 0; c < 16; c++) begin
        pat = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
        run_cmd(kd[0], c[3:0], -1);
      end
    end
    // requests while busy: early, mid-strobe, and in the last busy cycle
    run_cmd(1'b1, 4'd7, 0);
    run_cmd(1'b1, 4'd13, 2 + NS + 1);
    run_cmd(1'b1, 4'd9, 2 + NS + NB + NH - 1);
    pat = ~pat;
    run_cmd(1'b0, 4'd10, 1);
    run_cmd(1'b0, 4'd14, 2 + NS - 1);
    run_cmd(1'b0, 4'd3, 2 + NS - 1);
    // back-to-back after the same-cycle drop
    run_cmd(1'b0, 4'd8, -1);
    fin = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule